// File: doc/BRIEF.md
# Dual-Class In-Order Issue Unit

This unit sits between instruction fetch and the execution pipes. Each cycle it sees one aligned fetch pair of two instruction words. It decides which of them leave for execution. Every word arrives with a class bit that was set when the line was filled, and no opcode decode is done here. The bit marks the word as a floating-point ALU operation or as any other instruction. Each word also carries a resource mask naming the long-latency units it needs. By default unit 0 is the integer multiply/divide unit and unit 1 is the floating-point divide/square-root unit.

At most one instruction of each class issues per cycle, and issue always follows program order. When a pair holds two words of the same class, the older word issues. The younger word is captured in a one-entry hold register and is presented alone as the older slot on the next cycle. When the older instruction needs a busy unit, the pipeline slips and nothing issues. The pair is consumed only when its older word issues. A fetch that lands on the odd word, as a branch target can, offers just one instruction.

Top module: `dci_issue_unit`

## Requirements
- R1: After reset the hold register is empty: with no valid fetch, issue_o is 00, slip_o is 0 and fetch_take_o is 0.
- R2: For an even-start pair whose two words have different classes (fetch_cls_i bit k is 1 for floating point, 0 for other, with word k as slot k) and no busy need, both words issue (issue_o = 11) and the pair is taken.
- R3: For an even-start pair of the same class, only the older word issues (issue_o = 01) and the pair is taken. On the next cycle the held younger word issues alone from slot 0 and the new pair is not taken.
- R4: When fetch_odd_i is 1, only word 1 is considered. Word 0's class and needs have no effect, and issue_o[1] stays 0.
- R5: When the older instruction needs a unit whose busy bit is set, slip_o is 1 and issue_o is 00. The pair is not taken. fetch_need_i bits [NU*k +: NU] belong to word k, and bit u of a mask matches res_busy_i[u].
- R6: The younger slot never issues while the older does not, even when it is of the other class and free.
- R7: When the older word issues but the younger word needs a busy unit, the younger word is held and the pair is taken.
- R8: fp_go_o is 1 when an issuing instruction has class 1, and int_go_o is 1 when an issuing instruction has class 0. The number of set strobes equals the number of set issue_o bits.
- R9: A held instruction whose unit is busy slips, and it remains held until the unit frees. It then issues with fetch_take_o still 0.
- R10: With fetch_vld_i at 0 and the hold register empty, nothing issues and nothing slips.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pipeline clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fetch_vld_i | input | 1 | Fetch pair present |
| fetch_odd_i | input | 1 | Fetch starts at word 1 |
| fetch_cls_i | input | 2 | Class bit per word, 1 = floating-point ALU |
| fetch_need_i | input | 2*NU | Long-latency unit mask per word |
| res_busy_i | input | NU | Busy flag per long-latency unit |
| issue_o | output | 2 | Issue strobe: bit 0 older slot, bit 1 younger slot |
| slip_o | output | 1 | Older instruction blocked this cycle |
| fetch_take_o | output | 1 | Fetch pair consumed |
| fp_go_o | output | 1 | Instruction sent to the floating-point pipe |
| int_go_o | output | 1 | Instruction sent to the integer pipe |

## Verification
The bench targets the cases where order can break. A free younger word of the other class sits behind a slipping older word. A design that looked at each slot on its own would let that younger word issue ahead of the blocked one. Same-class pairs and pairs with a blocked younger word test the hold path. A unit without it would drop the younger word, or would take the next pair while the held word still waited. Odd-start fetches carry garbage tags in word 0, which exposes a selector that reads the wrong word. A reset taken while an instruction is held shows whether a stale word would issue after reset.

// File: rtl/dci_pkg.sv
package dci_pkg;
  typedef enum logic {
    CLS_OTHER = 1'b0,
    CLS_FP    = 1'b1
  } cls_e;

  localparam int unsigned NUM_WORDS = 2;
endpackage

// File: rtl/dci_hazard.sv
module dci_hazard #(
  parameter int unsigned NU = 2
) (
  input  logic [NU-1:0] need_i,
  input  logic [NU-1:0] busy_i,
  output logic          blocked_o
);
  assign blocked_o = |(need_i & busy_i);
endmodule

// File: rtl/dci_window.sv
module dci_window #(
  parameter int unsigned NU = 2
) (
  input  logic                 hold_vld_i,
  input  dci_pkg::cls_e        hold_cls_i,
  input  logic [NU-1:0]        hold_need_i,
  input  logic                 fetch_vld_i,
  input  logic                 fetch_odd_i,
  input  logic [1:0]           fetch_cls_i,
  input  logic [2*NU-1:0]      fetch_need_i,
  output logic                 old_vld_o,
  output dci_pkg::cls_e        old_cls_o,
  output logic [NU-1:0]        old_need_o,
  output logic                 yng_vld_o,
  output dci_pkg::cls_e        yng_cls_o,
  output logic [NU-1:0]        yng_need_o
);
  import dci_pkg::*;

  always_comb begin
    yng_cls_o  = cls_e'(fetch_cls_i[1]);
    yng_need_o = fetch_need_i[NU +: NU];
    if (hold_vld_i) begin
      // held younger word goes first, alone
      old_vld_o  = 1'b1;
      old_cls_o  = hold_cls_i;
      old_need_o = hold_need_i;
      yng_vld_o  = 1'b0;
    end else if (fetch_odd_i) begin
      old_vld_o  = fetch_vld_i;
      old_cls_o  = cls_e'(fetch_cls_i[1]);
      old_need_o = fetch_need_i[NU +: NU];
      yng_vld_o  = 1'b0;
    end else begin
      old_vld_o  = fetch_vld_i;
      old_cls_o  = cls_e'(fetch_cls_i[0]);
      old_need_o = fetch_need_i[0 +: NU];
      yng_vld_o  = fetch_vld_i;
    end
  end
endmodule

// File: rtl/dci_issue_unit.sv
module dci_issue_unit #(
  parameter int unsigned NU = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            fetch_vld_i,
  input  logic            fetch_odd_i,
  input  logic [1:0]      fetch_cls_i,
  input  logic [2*NU-1:0] fetch_need_i,
  input  logic [NU-1:0]   res_busy_i,
  output logic [1:0]      issue_o,
  output logic            slip_o,
  output logic            fetch_take_o,
  output logic            fp_go_o,
  output logic            int_go_o
);
  import dci_pkg::*;

  localparam int unsigned NW = NUM_WORDS;

  logic          hold_vld_q;
  cls_e          hold_cls_q;
  logic [NU-1:0] hold_need_q;

  logic          old_vld, yng_vld;
  cls_e          old_cls, yng_cls;
  logic [NU-1:0] slot_need [NW];
  logic [NW-1:0] slot_blk;
  logic          old_go, yng_go, load_hold;

  dci_window #(.NU(NU)) u_win (
    .hold_vld_i  (hold_vld_q),
    .hold_cls_i  (hold_cls_q),
    .hold_need_i (hold_need_q),
    .fetch_vld_i (fetch_vld_i),
    .fetch_odd_i (fetch_odd_i),
    .fetch_cls_i (fetch_cls_i),
    .fetch_need_i(fetch_need_i),
    .old_vld_o   (old_vld),
    .old_cls_o   (old_cls),
    .old_need_o  (slot_need[0]),
    .yng_vld_o   (yng_vld),
    .yng_cls_o   (yng_cls),
    .yng_need_o  (slot_need[1])
  );

  for (genvar s = 0; s < NW; s++) begin : g_haz
    dci_hazard #(.NU(NU)) u_haz (
      .need_i   (slot_need[s]),
      .busy_i   (res_busy_i),
      .blocked_o(slot_blk[s])
    );
  end

  assign old_go = old_vld & ~slot_blk[0];
  // younger only behind an issuing older of the other class
  assign yng_go = old_go & yng_vld & (yng_cls != old_cls) & ~slot_blk[1];
  assign load_hold = old_go & yng_vld & ~yng_go;

  assign issue_o      = {yng_go, old_go};
  assign slip_o       = old_vld & slot_blk[0];
  assign fetch_take_o = fetch_vld_i & ~hold_vld_q & old_go;
  assign fp_go_o      = (old_go & (old_cls == CLS_FP)) | (yng_go & (yng_cls == CLS_FP));
  assign int_go_o     = (old_go & (old_cls == CLS_OTHER)) | (yng_go & (yng_cls == CLS_OTHER));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_vld_q  <= 1'b0;
      hold_cls_q  <= CLS_OTHER;
      hold_need_q <= '0;
    end else if (load_hold) begin
      hold_vld_q  <= 1'b1;
      hold_cls_q  <= yng_cls;
      hold_need_q <= slot_need[1];
    end else if (old_go) begin
      hold_vld_q  <= 1'b0;
    end
  end
endmodule

// File: rtl/dci_issue_chk.sv
module dci_issue_chk #(
  parameter int unsigned NU = 2
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       fetch_vld_i,
  input logic       fetch_odd_i,
  input logic [1:0] issue_o,
  input logic       slip_o,
  input logic       fetch_take_o,
  input logic       fp_go_o,
  input logic       int_go_o
);
  // R5
  slip_no_issue_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slip_o |-> (issue_o == 2'b00 && !fetch_take_o));
  // R6
  in_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_o[1] |-> issue_o[0]);
  // R4
  odd_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_vld_i && fetch_odd_i) |-> !issue_o[1]);
  // R3
  held_stalls_fetch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_take_o && !fetch_odd_i && !issue_o[1]) |=> !fetch_take_o);
  // R8
  class_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(issue_o) == $countones({fp_go_o, int_go_o}));
  // R2
  dual_split_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_o == 2'b11) |-> (fp_go_o && int_go_o));
endmodule

bind dci_issue_unit dci_issue_chk #(.NU(NU)) u_chk (.*);

// File: tb/dci_issue_unit_test.sv
module dci_issue_unit_test;
  localparam int unsigned NU = 2;
  localparam time CLK_PERIOD = 10;
  localparam int NVEC = 9;
  // {vld, odd, cls[1:0], need[3:0], busy[1:0]} , {issue[1:0], slip, take, fp, int}
  localparam logic [15:0] VEC [NVEC] = '{
    16'b1_0_10_0000_00_11_0_1_1_1,  // R2
    16'b1_0_01_0000_00_11_0_1_1_1,  // R2
    16'b1_0_10_0001_01_00_1_0_0_0,  // R5 R6
    16'b1_0_10_0001_10_11_0_1_1_1,  // R2
    16'b1_1_10_0000_00_01_0_1_1_0,  // R4
    16'b1_1_01_0001_01_01_0_1_0_1,  // R4
    16'b0_0_10_0000_11_00_0_0_0_0,  // R10
    16'b1_1_10_1000_10_00_1_0_0_0,  // R5
    16'b1_0_01_0100_00_11_0_1_1_1   // R8
  };
  localparam string VTAG [NVEC] = '{"R2", "R2", "R6", "R2", "R4", "R4", "R10", "R5", "R8"};

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic fetch_vld_i = 1'b0, fetch_odd_i = 1'b0;
  logic [1:0] fetch_cls_i = '0;
  logic [2*NU-1:0] fetch_need_i = '0;
  logic [NU-1:0] res_busy_i = '0;
  logic [1:0] issue_o;
  logic slip_o, fetch_take_o, fp_go_o, int_go_o;
  int n_chk = 0, n_fail = 0;

  dci_issue_unit #(.NU(NU)) uut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic drive(input logic [9:0] s);
    @(negedge clk_i);
    {fetch_vld_i, fetch_odd_i, fetch_cls_i, fetch_need_i, res_busy_i} = s;
    #2;
  endtask

  task automatic check(input string tag, input logic [5:0] exp);
    logic [5:0] act;
    act = {issue_o, slip_o, fetch_take_o, fp_go_o, int_go_o};
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {issue,slip,take,fp,int} actual %b expected %b", tag, act, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 2 + 3);
    rst_ni = 1'b1;
    drive(10'b0_0_00_0000_00); check("R1", 6'b00_0_0_0_0);

    for (int i = 0; i < NVEC; i++) begin
      drive(VEC[i][15:6]);
      check(VTAG[i], VEC[i][5:0]);
    end

    // R3 same-class pair, then held word alone, then next pair
    drive(10'b1_0_00_0000_00); check("R3", 6'b01_0_1_0_1);
    drive(10'b1_0_10_0000_00); check("R3", 6'b01_0_0_0_1);
    drive(10'b1_0_10_0000_00); check("R3", 6'b11_0_1_1_1);

    // R7 younger blocked, then R9 held word slips and later issues
    drive(10'b1_0_10_1000_10); check("R7", 6'b01_0_1_0_1);
    drive(10'b1_0_10_0000_10); check("R9", 6'b00_1_0_0_0);
    drive(10'b1_0_10_0000_10); check("R9", 6'b00_1_0_0_0);
    drive(10'b1_0_10_0000_00); check("R9", 6'b01_0_0_1_0);
    drive(10'b0_0_00_0000_00); check("R10", 6'b00_0_0_0_0);

    // R3 two FP words: held FP goes through the FP strobe (R8)
    drive(10'b1_0_11_0000_00); check("R3", 6'b01_0_1_1_0);
    drive(10'b0_0_00_0000_00); check("R8", 6'b01_0_0_1_0);
    drive(10'b0_0_00_0000_00); check("R10", 6'b00_0_0_0_0);

    // R1 reset clears a held word
    drive(10'b1_0_00_0000_00); check("R3", 6'b01_0_1_0_1);
    @(negedge clk_i);
    fetch_vld_i = 1'b0;
    rst_ni = 1'b0;
    #2;
    rst_ni = 1'b1;
    drive(10'b0_0_00_0000_00); check("R1", 6'b00_0_0_0_0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule